// File: doc/BRIEF.md
# Pin Falling-Edge Interrupt Unit

This unit watches the 24 input pins of a host-controlled I/O expander, grouped as three 8-bit ports. Each pin has its own enable bit. When an enabled pin goes from high to low, the unit sets a sticky event bit for that pin. While any event bit is set, it holds an active-low interrupt line asserted so that the host knows to come and look.

The host uses a simple register port. It can program the chip address and the per-pin enables, and it can read the synchronized pin levels and the event bits. The host clears events by sending a command byte, not by writing to a register. A command is carried out only when the programmed chip address equals the three address strap pins. This lets several expanders share one host bus, with each one acting only on its own commands.

Top module: `pin_fall_irq`

## Requirements
- R1: After reset, every register reads zero and `irq_n` is high.
- R2: Register map on `reg_addr`. Address 0 holds the chip address in bits [2:0] (read/write). Addresses 1, 2 and 3 return the live synchronized levels of ports 0, 1 and 2, and writes to them are ignored. Addresses 4, 5 and 6 are the enable registers of ports 0, 1 and 2 (read/write). Addresses 7, 8 and 9 are the event registers of ports 0, 1 and 2, and writes to them are ignored. Every other address reads zero. Bit i of port p belongs to pin 8p+i. A read has no side effect.
- R3: An event bit is set only by a 1-to-0 transition of its pin while that pin's enable bit is 1. Rising edges and edges on pins whose enable bit is 0 set nothing.
- R4: An event bit stays set until a clear command is executed. Writing its enable bit to 0 does not clear it.
- R5: `irq_n` goes low one clock after any event bit is set. It goes high one clock after all event bits are zero.
- R6: With `cmd_valid` high, the command code 0x13 clears all 24 event bits. Every other code has no effect.
- R7: A command is executed only when the chip-address register equals `addr_strap`. Otherwise it is ignored.
- R8: If a new falling edge and an executed clear happen in the same cycle, the new event bit remains set while the other bits clear.
- R9: A pin change is first captured at the next rising edge. The event bit reads as set after the third rising edge from the pin change, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | 24 | Raw pin levels, pin 8p+i is bit i of port p |
| addr_strap | input | 3 | Address strap pins |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_code | input | 8 | Command byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach from the ports is a clear command that lands in the exact cycle in which a newly synchronized falling edge becomes visible. The bench counts edges from the pin drive: it drives the pin between edges, waits two rising edges for the synchronizer, and then raises the clear command for the single following edge. An older event is set on purpose beforehand, so that one result shows both that the clear was accepted and that the new event survived. The bench also sweeps every pin one at a time against a single enable, all eight chip addresses, and all 256 command codes.

// File: rtl/pfi_pkg.sv
package pfi_pkg;
    // command byte that wipes the event registers
    localparam logic [7:0] CMD_CLR_EVT = 8'h13;
    // register address of the chip-address register
    localparam int A_CHIP = 0;
    // first input-level register; enables and events follow in port-sized groups
    localparam int A_PIN0 = 1;
endpackage

// File: rtl/pfi_sync.sv
module pfi_sync #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/pfi_fall_detect.sv
module pfi_fall_detect #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // previous sample high, current sample low
    assign fall = prev_q & ~cur;
endmodule

// File: rtl/pfi_cmd_decode.sv
module pfi_cmd_decode #(
    parameter int CHIP_AW = 3
) (
    input  logic               cmd_valid,
    input  logic [7:0]         cmd_code,
    input  logic [CHIP_AW-1:0] chip_addr,
    input  logic [CHIP_AW-1:0] strap,
    output logic               clr_hit
);
    import pfi_pkg::*;

    logic selected;

    always_comb begin
        selected = (chip_addr == strap);
        clr_hit  = cmd_valid && selected && (cmd_code == CMD_CLR_EVT);
    end
endmodule

// File: rtl/pin_fall_irq.sv
module pin_fall_irq #(
    parameter int NUM_PORTS = 3,
    parameter int PORT_W    = 8,
    parameter int CHIP_AW   = 3,
    parameter int REG_AW    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS*PORT_W-1:0]   pins_in,
    input  logic [CHIP_AW-1:0]            addr_strap,
    input  logic                          cmd_valid,
    input  logic [7:0]                    cmd_code,
    input  logic                          reg_wr,
    input  logic [REG_AW-1:0]             reg_addr,
    input  logic [PORT_W-1:0]             reg_wdata,
    output logic [PORT_W-1:0]             reg_rdata,
    output logic                          irq_n
);
    import pfi_pkg::*;

    localparam int NPINS  = NUM_PORTS * PORT_W;
    localparam int A_EN0  = A_PIN0 + NUM_PORTS;
    localparam int A_EVT0 = A_EN0 + NUM_PORTS;

    typedef struct packed {
        logic [CHIP_AW-1:0] chip;
        logic [NPINS-1:0]   en;
        logic [NPINS-1:0]   evt;
        logic               irq_act;
    } state_t;

    state_t st_d, st_q;

    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] fall_w;
    logic             clr_hit;
    logic [NPINS-1:0] en_q;
    logic [NPINS-1:0] evt_q;

    pfi_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_in),
        .q     (pin_sync)
    );

    pfi_fall_detect #(.W(NPINS)) u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (pin_sync),
        .fall  (fall_w)
    );

    pfi_cmd_decode #(.CHIP_AW(CHIP_AW)) u_cmd (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .chip_addr (st_q.chip),
        .strap     (addr_strap),
        .clr_hit   (clr_hit)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            if (reg_addr == REG_AW'(A_CHIP))
                st_d.chip = reg_wdata[CHIP_AW-1:0];
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (reg_addr == REG_AW'(A_EN0 + p))
                    st_d.en[p*PORT_W +: PORT_W] = reg_wdata;
            end
        end
        // a fresh edge outranks a clear in the same cycle
        st_d.evt     = (clr_hit ? '0 : st_q.evt) | (fall_w & st_q.en);
        st_d.irq_act = |st_q.evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux, no side effects
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(A_CHIP))
            reg_rdata[CHIP_AW-1:0] = st_q.chip;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (reg_addr == REG_AW'(A_PIN0 + p))
                reg_rdata = pin_sync[p*PORT_W +: PORT_W];
            if (reg_addr == REG_AW'(A_EN0 + p))
                reg_rdata = st_q.en[p*PORT_W +: PORT_W];
            if (reg_addr == REG_AW'(A_EVT0 + p))
                reg_rdata = st_q.evt[p*PORT_W +: PORT_W];
        end
    end

    assign en_q  = st_q.en;
    assign evt_q = st_q.evt;
    assign irq_n = ~st_q.irq_act;
endmodule

// File: rtl/pfi_chk.sv
module pfi_chk #(
    parameter int N = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr_hit,
    input logic [N-1:0] fall,
    input logic [N-1:0] en,
    input logic [N-1:0] evt,
    input logic         irq_n
);
    // R4
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_hit |=> ((evt & $past(evt)) == $past(evt)));

    // R3
    evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |-> ((evt & ~$past(evt) & ~($past(fall) & $past(en))) == '0));

    // R6
    clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> ((evt & ~($past(fall) & $past(en))) == '0));

    // R8
    clr_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && |(fall & en)) |=> ((evt & $past(fall & en)) == $past(fall & en)));

    // R5
    irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> !irq_n);

    // R5
    irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|evt) |=> irq_n);
endmodule

bind pin_fall_irq pfi_chk #(.N(NUM_PORTS*PORT_W)) u_pfi_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_hit (clr_hit),
    .fall    (fall_w),
    .en      (en_q),
    .evt     (evt_q),
    .irq_n   (irq_n)
);

// File: tb/tb_pin_fall_irq.sv
module tb_pin_fall_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pins_in = 24'hFFFFFF;
    logic [2:0]  addr_strap = 3'd5;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        irq_n;

    int n_chk = 0;
    int n_bad = 0;
    logic [23:0] ev;
    logic [7:0]  rd;

    always #4 clk = ~clk;

    pin_fall_irq dut (
        .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .addr_strap(addr_strap),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_events(output logic [23:0] e);
        logic [7:0] b0, b1, b2;
        rdreg(4'd7, b0); rdreg(4'd8, b1); rdreg(4'd9, b2);
        e = {b2, b1, b0};
    endtask

    task automatic set_en(input logic [23:0] m);
        wr(4'd4, m[7:0]); wr(4'd5, m[15:8]); wr(4'd6, m[23:16]);
    endtask

    task automatic cmd(input logic [7:0] c);
        cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1 reset state, R2 unused addresses read zero
        for (int a = 0; a < 16; a++) begin
            rdreg(4'(a), rd);
            if (a >= 1 && a <= 3) chk("R1 pin read idle", {24'd0, rd}, 32'hFF);
            else                  chk("R1 reset register zero", {24'd0, rd}, 32'h0);
        end
        chk("R1 irq_n idle", {31'd0, irq_n}, 32'd1);

        // R2 chip address read/write, read-only registers ignore writes
        wr(4'd0, 8'hFD);
        rdreg(4'd0, rd);
        chk("R2 chip addr readback", {24'd0, rd}, 32'h5);
        wr(4'd1, 8'h00); wr(4'd7, 8'hFF); wr(4'd12, 8'hFF);
        rdreg(4'd1, rd); chk("R2 pin reg ignores write", {24'd0, rd}, 32'hFF);
        rdreg(4'd7, rd); chk("R2 event reg ignores write", {24'd0, rd}, 32'h0);
        rdreg(4'd12, rd); chk("R2 unused addr", {24'd0, rd}, 32'h0);
        set_en(24'hA1B2C3);
        rdreg(4'd4, rd); chk("R2 enable p0", {24'd0, rd}, 32'hC3);
        rdreg(4'd6, rd); chk("R2 enable p2", {24'd0, rd}, 32'hA1);
        set_en(24'h0);

        // R2 live pin levels per port
        pins_in = 24'h3C96A5;
        settle();
        rdreg(4'd1, rd); chk("R2 pin p0", {24'd0, rd}, 32'hA5);
        rdreg(4'd2, rd); chk("R2 pin p1", {24'd0, rd}, 32'h96);
        rdreg(4'd3, rd); chk("R2 pin p2", {24'd0, rd}, 32'h3C);
        rd_events(ev); chk("R3 disabled pins stay clear", {8'd0, ev}, 32'h0);
        pins_in = 24'hFFFFFF;
        settle();

        // R3 R5 sweep: each pin alone enabled, all pins fall
        for (int k = 0; k < 24; k++) begin
            set_en(24'(1) << k);
            pins_in = 24'h000000;
            settle();
            rd_events(ev);
            chk("R3 single enabled pin", {8'd0, ev}, {8'd0, 24'(1) << k});
            chk("R5 irq asserted", {31'd0, irq_n}, 32'd0);
            pins_in = 24'hFFFFFF;
            settle();
            rd_events(ev);
            chk("R3 rising edge ignored", {8'd0, ev}, {8'd0, 24'(1) << k});
            cmd(8'h13);
            @(negedge clk);
            rd_events(ev);
            chk("R6 clear", {8'd0, ev}, 32'h0);
            chk("R5 irq released", {31'd0, irq_n}, 32'd1);
        end

        // R9 latency: captured after third edge, not second
        set_en(24'hFFFFFF);
        pins_in = 24'hFFFFFE;
        @(posedge clk); @(posedge clk); #1;
        rd_events(ev); chk("R9 not yet after two edges", {8'd0, ev}, 32'h0);
        @(posedge clk); #1;
        rd_events(ev); chk("R9 set after three edges", {8'd0, ev}, 32'h1);
        @(posedge clk); #1;
        chk("R5 irq one edge after event", {31'd0, irq_n}, 32'd0);
        @(negedge clk);
        pins_in = 24'hFFFFFF;
        settle();
        cmd(8'h13);
        settle();

        // R6 every other command code leaves events alone
        pins_in = 24'h000000;
        settle();
        for (int c = 0; c < 256; c++) begin
            if (c != 8'h13) cmd(8'(c));
        end
        rd_events(ev); chk("R6 other codes no effect", {8'd0, ev}, 32'hFFFFFF);

        // R4 disabling does not clear
        set_en(24'h0);
        rd_events(ev); chk("R4 disable keeps events", {8'd0, ev}, 32'hFFFFFF);
        set_en(24'hFFFFFF);

        // R7 chip address sweep: clear only when equal to strap (5)
        for (int a = 0; a < 8; a++) begin
            pins_in = 24'hFFFFFF;
            settle();
            pins_in = 24'h000000;
            settle();
            wr(4'd0, 8'(a));
            cmd(8'h13);
            settle();
            rd_events(ev);
            chk("R7 address gate", {8'd0, ev}, (a == 5) ? 32'h0 : 32'hFFFFFF);
        end
        wr(4'd0, 8'd5);

        // R8 clear arriving with a fresh edge
        pins_in = 24'hFFFFFF;
        settle();
        cmd(8'h13);
        set_en(24'h000201);
        pins_in = 24'hFFFFFE;
        settle();
        rd_events(ev); chk("R8 prior event", {8'd0, ev}, 32'h1);
        @(negedge clk);
        pins_in = 24'hFFFDFE;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 8'h13;
        @(negedge clk);
        cmd_valid = 1'b0;
        rd_events(ev); chk("R8 new event survives clear", {8'd0, ev}, 32'h200);
        settle();
        chk("R5 irq held by survivor", {31'd0, irq_n}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule